// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block sits beside a 32-bit processor core and compresses its per-cycle execution events into two 4-bit output streams for an external debug probe. The first stream, the status code, says what the core did in each cycle: it started an instruction, it took a branch, it is processing an exception, it is halted, or nothing happened. The second stream, the data nibbles, carries values selected for display, such as branch targets and operand values, one nibble per cycle.

Each selected value is placed in a small queue. When the status stream has a free cycle, the value is announced by a marker code. That marker gives the value's kind or size. The value's nibbles then follow on the data stream, least significant nibble first. A 4-bit configuration input decides which categories are shown. Some accesses are always kept off the stream by fixed rules: the two fetches that follow reset, line-sized burst transfers of multi-register moves, and jumps whose addressing mode is absolute or immediate. When the queue is full, the block raises a stall request toward the core.

If a taken branch and an operand capture arrive in the same cycle, only the branch target is queued.

Top module: `trc_status_enc`

## Requirements
- R1: After reset, the status output is 0x0, the data output is 0x0 and the stall request is low.
- R2: A cycle with halt asserted gives status 0xF in the next cycle. Halt takes priority over every other status code.
- R3: A taken branch gives status 0x5 in the next cycle, unless halt is also asserted. If cfg bit 0 is set, the target is then queued behind marker 0xD as eight nibbles. If cfg bit 0 is clear, no marker is issued.
- R4: When the jump flag is set, the target is shown only for addressing-mode codes 0 to 3. These are register indirect, displacement, indexed and PC-indexed. Codes 4 to 7 (absolute and immediate forms) never queue a target.
- R5: An instruction start gives status 0x1 in the next cycle when neither halt nor a taken branch is present.
- R6: An operand capture is queued under a marker that depends on its size code. Size 0 (byte) uses marker 0x8 and 2 nibbles, enabled by cfg bit 1. Size 1 (word) uses marker 0x9 and 4 nibbles, enabled by cfg bit 2. Sizes 2 and 3 (long) use marker 0xB and 8 nibbles, enabled by cfg bit 3.
- R7: A capture whose size category is disabled in cfg produces no marker and no data nibbles.
- R8: The first two capture requests after reset are discarded, whatever their size or the cfg setting.
- R9: A multi-register-move capture is discarded when its address bits [3:0] are zero and four or more registers remain.
- R10: While exception processing is active, the status is 0xC in every cycle that carries no halt, branch, instruction-start or marker code. A marker still displaces 0xC.
- R11: A marker is issued only in a cycle with no halt, branch or instruction start. Its nibbles appear on the data output in the following cycles, least significant first. The data output is 0x0 whenever no nibble is due.
- R12: The queue holds four entries. The stall request is high exactly while four entries are held. A request that arrives while the queue is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_start_i | input | 1 | An instruction starts this cycle |
| halt_i | input | 1 | Core is halted |
| exc_i | input | 1 | Exception processing is active |
| br_taken_i | input | 1 | A branch or jump is taken this cycle |
| br_jmp_i | input | 1 | The taken branch is a jump or jump-to-subroutine |
| br_ea_i | input | 3 | Addressing-mode code of the jump (0-3 variant, 4-7 absolute or immediate) |
| br_tgt_i | input | 32 | Branch target address |
| cap_valid_i | input | 1 | Operand capture request |
| cap_size_i | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| cap_data_i | input | 32 | Operand value |
| cap_movem_i | input | 1 | Capture belongs to a multi-register move |
| cap_addr_lo_i | input | 4 | Low operand address bits |
| cap_left_i | input | 5 | Registers still to transfer in the move |
| cfg_i | input | 4 | Enables: bit0 target, bit1 byte, bit2 word, bit3 long |
| pst_o | output | 4 | Processor status code |
| ddata_o | output | 4 | Debug data nibble |
| stall_o | output | 1 | Stall request, high while the queue is full |

## Verification
The hardest state to reach from the ports is a full queue. Reaching it needs requests to arrive faster than the single serializer drains them. The stimulus sends long captures on consecutive cycles, so that each eight-nibble word holds the serializer while more entries pile up. It then checks that the stall request rises on the cycle the fourth entry is held, and that a sixth request never shows up on the stream. A second case that is hard to reach is a marker delayed by higher-priority codes. This is produced by holding instruction start high after a capture and watching for the marker to appear only once the status stream is free.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam int unsigned TRC_DW  = 32;
  localparam int unsigned TRC_NIB = 4;

  // configuration bit positions
  localparam int unsigned CFG_TGT  = 0;
  localparam int unsigned CFG_BYTE = 1;
  localparam int unsigned CFG_WORD = 2;
  localparam int unsigned CFG_LONG = 3;

  // highest addressing-mode code that still shows a jump target
  localparam logic [2:0] EA_LAST_VARIANT = 3'd3;

  typedef enum logic [3:0] {
    PST_IDLE    = 4'h0,
    PST_INSN    = 4'h1,
    PST_BRANCH  = 4'h5,
    PST_MK_BYTE = 4'h8,
    PST_MK_WORD = 4'h9,
    PST_MK_LONG = 4'hB,
    PST_EXC     = 4'hC,
    PST_MK_TGT  = 4'hD,
    PST_HALT    = 4'hF
  } pst_e;

  typedef struct packed {
    pst_e              mark;
    logic [TRC_DW-1:0] word;
  } trc_item_t;

  function automatic logic [3:0] item_nibbles(input pst_e m);
    case (m)
      PST_MK_BYTE: item_nibbles = 4'd2;
      PST_MK_WORD: item_nibbles = 4'd4;
      default:     item_nibbles = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/trc_capture_filter.sv
module trc_capture_filter
  import trc_pkg::*;
#(
  parameter int unsigned BOOT_SKIP  = 2,
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned MIN_REGS   = 4,
  parameter int unsigned LEFT_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_valid_i,
  input  logic [1:0]            cap_size_i,
  input  logic [TRC_DW-1:0]     cap_data_i,
  input  logic                  cap_movem_i,
  input  logic [ALIGN_BITS-1:0] cap_addr_lo_i,
  input  logic [LEFT_W-1:0]     cap_left_i,
  input  logic                  br_taken_i,
  input  logic                  br_jmp_i,
  input  logic [2:0]            br_ea_i,
  input  logic [TRC_DW-1:0]     br_tgt_i,
  input  logic [3:0]            cfg_i,
  output logic                  push_o,
  output trc_item_t             item_o
);

  localparam int unsigned BW = $clog2(BOOT_SKIP + 1);

  logic [BW-1:0] boot_q, boot_d;
  logic          boot_en, boot_done;
  logic          line_xfer, size_on, op_ok, tgt_ok;
  pst_e          op_mark;

  // counting of the post-reset fetches that are never shown
  always_comb begin
    boot_done = (boot_q == BW'(BOOT_SKIP));
    boot_en   = cap_valid_i && !boot_done;
    boot_d    = boot_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       boot_q <= '0;
    else if (boot_en) boot_q <= boot_d;
  end

  always_comb begin
    line_xfer = cap_movem_i && (cap_addr_lo_i == '0) &&
                (cap_left_i >= LEFT_W'(MIN_REGS));
    case (cap_size_i)
      2'd0: begin op_mark = PST_MK_BYTE; size_on = cfg_i[CFG_BYTE]; end
      2'd1: begin op_mark = PST_MK_WORD; size_on = cfg_i[CFG_WORD]; end
      default: begin op_mark = PST_MK_LONG; size_on = cfg_i[CFG_LONG]; end
    endcase
    op_ok  = cap_valid_i && boot_done && !line_xfer && size_on;
    tgt_ok = br_taken_i && cfg_i[CFG_TGT] &&
             (!br_jmp_i || (br_ea_i <= EA_LAST_VARIANT));
    push_o = tgt_ok || op_ok;
    if (tgt_ok) begin
      item_o.mark = PST_MK_TGT;
      item_o.word = br_tgt_i;
    end else begin
      item_o.mark = op_mark;
      item_o.word = cap_data_i;
    end
  end

endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en, rd_en;

  always_comb begin
    empty_o = (cnt_q == '0);
    full_o  = (cnt_q == CW'(DEPTH));
    wr_en   = push_i && !full_o;
    rd_en   = pop_i && !empty_o;
    wr_d    = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    rd_d    = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    cnt_d   = cnt_q + CW'(wr_en) - CW'(rd_en);
    dout_o  = mem_q[rd_q];
    count_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en)          wr_q  <= wr_d;
      if (rd_en)          rd_q  <= rd_d;
      if (wr_en != rd_en) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_q] <= din_i;
  end

endmodule

// File: rtl/trc_serializer.sv
module trc_serializer #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NW   = 4,
  localparam int unsigned CNTW = $clog2(DW / NW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [DW-1:0]   word_i,
  input  logic [CNTW-1:0] nibs_i,
  output logic            ready_o,
  output logic [NW-1:0]   dd_o
);

  logic [DW-1:0]   sh_q, sh_d;
  logic [CNTW-1:0] rem_q, rem_d;
  logic [NW-1:0]   dd_q, dd_d;
  logic            active;

  always_comb begin
    active  = (rem_q != '0);
    ready_o = (rem_q <= CNTW'(1));
    dd_d    = active ? sh_q[NW-1:0] : '0;
    if (load_i) begin
      sh_d  = word_i;
      rem_d = nibs_i;
    end else begin
      sh_d  = sh_q >> NW;
      rem_d = rem_q - CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
      dd_q  <= '0;
    end else begin
      if (load_i || active) begin
        sh_q  <= sh_d;
        rem_q <= rem_d;
      end
      dd_q <= dd_d;
    end
  end

  assign dd_o = dd_q;

endmodule

// File: rtl/trc_status_enc.sv
module trc_status_enc
  import trc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned BOOT_SKIP  = 2,
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned MIN_REGS   = 4,
  parameter int unsigned LEFT_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  insn_start_i,
  input  logic                  halt_i,
  input  logic                  exc_i,
  input  logic                  br_taken_i,
  input  logic                  br_jmp_i,
  input  logic [2:0]            br_ea_i,
  input  logic [31:0]           br_tgt_i,
  input  logic                  cap_valid_i,
  input  logic [1:0]            cap_size_i,
  input  logic [31:0]           cap_data_i,
  input  logic                  cap_movem_i,
  input  logic [ALIGN_BITS-1:0] cap_addr_lo_i,
  input  logic [LEFT_W-1:0]     cap_left_i,
  input  logic [3:0]            cfg_i,
  output logic [3:0]            pst_o,
  output logic [3:0]            ddata_o,
  output logic                  stall_o
);

  localparam int unsigned IW   = $bits(trc_item_t);
  localparam int unsigned CW   = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned CNTW = $clog2(TRC_DW / TRC_NIB + 1);

  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic          push, pop, fifo_empty, fifo_full, ser_ready;
  logic [CW-1:0] fifo_cnt;
  trc_item_t     push_item, head_item;
  logic [IW-1:0] head_bits;
  pst_e          pst_q, pst_d;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  trc_capture_filter #(
    .BOOT_SKIP (BOOT_SKIP),
    .ALIGN_BITS(ALIGN_BITS),
    .MIN_REGS  (MIN_REGS),
    .LEFT_W    (LEFT_W)
  ) u_filter (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cap_valid_i  (cap_valid_i),
    .cap_size_i   (cap_size_i),
    .cap_data_i   (cap_data_i),
    .cap_movem_i  (cap_movem_i),
    .cap_addr_lo_i(cap_addr_lo_i),
    .cap_left_i   (cap_left_i),
    .br_taken_i   (br_taken_i),
    .br_jmp_i     (br_jmp_i),
    .br_ea_i      (br_ea_i),
    .br_tgt_i     (br_tgt_i),
    .cfg_i        (cfg_i),
    .push_o       (push),
    .item_o       (push_item)
  );

  trc_fifo #(
    .W    (IW),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .push_i (push),
    .din_i  (push_item),
    .pop_i  (pop),
    .dout_o (head_bits),
    .empty_o(fifo_empty),
    .full_o (fifo_full),
    .count_o(fifo_cnt)
  );

  assign head_item = trc_item_t'(head_bits);

  trc_serializer #(
    .DW(TRC_DW),
    .NW(TRC_NIB)
  ) u_ser (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (pop),
    .word_i (head_item.word),
    .nibs_i (CNTW'(item_nibbles(head_item.mark))),
    .ready_o(ser_ready),
    .dd_o   (ddata_o)
  );

  // status priority: halt, branch, instruction, marker, exception, idle
  always_comb begin
    pop = !fifo_empty && ser_ready && !halt_i && !br_taken_i && !insn_start_i;
    if (halt_i)            pst_d = PST_HALT;
    else if (br_taken_i)   pst_d = PST_BRANCH;
    else if (insn_start_i) pst_d = PST_INSN;
    else if (pop)          pst_d = head_item.mark;
    else if (exc_i)        pst_d = PST_EXC;
    else                   pst_d = PST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pst_q <= PST_IDLE;
    else        pst_q <= pst_d;
  end

  assign pst_o   = pst_q;
  assign stall_o = fifo_full;

endmodule

// File: rtl/trc_status_enc_chk.sv
module trc_status_enc_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt_i,
  input logic          br_taken_i,
  input logic          insn_start_i,
  input logic          exc_i,
  input logic [3:0]    pst_o,
  input logic [CW-1:0] fifo_cnt
);

  // R2
  halt_pst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> pst_o == 4'hF);

  // R3
  branch_pst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_i && !halt_i |=> pst_o == 4'h5);

  // R5
  insn_pst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_start_i && !halt_i && !br_taken_i |=> pst_o == 4'h1);

  // R10
  exc_pst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i && !halt_i && !br_taken_i && !insn_start_i && fifo_cnt == '0
    |=> pst_o == 4'hC);

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

endmodule

bind trc_status_enc trc_status_enc_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .halt_i      (halt_i),
  .br_taken_i  (br_taken_i),
  .insn_start_i(insn_start_i),
  .exc_i       (exc_i),
  .pst_o       (pst_o),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/trc_status_enc_tb.sv
`timescale 1ns/1ps
module trc_status_enc_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_start_i, halt_i, exc_i, br_taken_i, br_jmp_i;
  logic [2:0]  br_ea_i;
  logic [31:0] br_tgt_i, cap_data_i;
  logic        cap_valid_i, cap_movem_i;
  logic [1:0]  cap_size_i;
  logic [3:0]  cap_addr_lo_i, cfg_i;
  logic [4:0]  cap_left_i;
  logic [3:0]  pst_o, ddata_o;
  logic        stall_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  logic [3:0]  exp_mark_q[$];
  logic [31:0] exp_word_q[$];
  string       exp_tag_q[$];

  always #2.5 clk = ~clk;

  trc_status_enc u_dut (
    .clk(clk), .rst_n(rst_n), .insn_start_i(insn_start_i), .halt_i(halt_i),
    .exc_i(exc_i), .br_taken_i(br_taken_i), .br_jmp_i(br_jmp_i),
    .br_ea_i(br_ea_i), .br_tgt_i(br_tgt_i), .cap_valid_i(cap_valid_i),
    .cap_size_i(cap_size_i), .cap_data_i(cap_data_i),
    .cap_movem_i(cap_movem_i), .cap_addr_lo_i(cap_addr_lo_i),
    .cap_left_i(cap_left_i), .cfg_i(cfg_i), .pst_o(pst_o),
    .ddata_o(ddata_o), .stall_o(stall_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int nibs_of(input logic [3:0] m);
    if (m == 4'h8) return 2;
    if (m == 4'h9) return 4;
    return 8;
  endfunction

  task automatic clear_in();
    insn_start_i = 0; halt_i = 0; br_taken_i = 0; br_jmp_i = 0;
    br_ea_i = 0; br_tgt_i = 0; cap_valid_i = 0; cap_size_i = 0;
    cap_data_i = 0; cap_movem_i = 0; cap_addr_lo_i = 0; cap_left_i = 0;
  endtask

  task automatic idle(input int n);
    clear_in();
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input logic [3:0] m, input logic [31:0] w, input string tag);
    exp_mark_q.push_back(m);
    exp_word_q.push_back(w);
    exp_tag_q.push_back(tag);
  endtask

  // one-cycle capture request; queues the expected item when shown
  task automatic cap(input logic [1:0] sz, input logic [31:0] d, input logic mv,
                     input logic [3:0] a, input logic [4:0] left,
                     input bit shown, input string tag);
    cap_valid_i = 1; cap_size_i = sz; cap_data_i = d;
    cap_movem_i = mv; cap_addr_lo_i = a; cap_left_i = left;
    if (shown)
      expect_item((sz == 2'd0) ? 4'h8 : (sz == 2'd1) ? 4'h9 : 4'hB, d, tag);
    @(negedge clk);
    cap_valid_i = 0; cap_movem_i = 0;
  endtask

  // one-cycle taken branch; checks the branch code in the next cycle
  task automatic branch(input logic jmp, input logic [2:0] ea, input logic [31:0] t,
                        input bit shown, input string tag);
    br_taken_i = 1; br_jmp_i = jmp; br_ea_i = ea; br_tgt_i = t;
    if (shown) expect_item(4'hD, t, tag);
    @(negedge clk);
    chk({tag, " branch code"}, pst_o, 4'h5);
    br_taken_i = 0; br_jmp_i = 0;
  endtask

  // scoreboard monitor: markers pop expected items, nibbles are compared
  int          mon_rem = 0;
  logic [31:0] mon_word;
  string       mon_tag;
  always @(negedge clk) begin
    if (mon_en) begin
      if (mon_rem > 0) begin
        chk({mon_tag, " nibble"}, ddata_o, mon_word[3:0]);
        mon_word = mon_word >> 4;
        mon_rem--;
      end else begin
        chk("R11 idle data", ddata_o, 4'h0);
      end
      if (pst_o == 4'h8 || pst_o == 4'h9 || pst_o == 4'hB || pst_o == 4'hD) begin
        if (exp_mark_q.size() == 0) begin
          chk("R4/R7/R8/R9/R12 unexpected marker", pst_o, 4'h0);
        end else begin
          mon_tag  = exp_tag_q.pop_front();
          mon_word = exp_word_q.pop_front();
          chk({mon_tag, " marker"}, pst_o, exp_mark_q.pop_front());
          mon_rem  = nibs_of(pst_o);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_in();
    exc_i = 0;
    cfg_i = 4'hF;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    mon_en = 1;

    // R1 reset state
    chk("R1 pst", pst_o, 4'h0);
    chk("R1 ddata", ddata_o, 4'h0);
    chk("R1 stall", stall_o, 1'b0);

    // R8 the first two captures vanish, the third is shown
    cap(2'd2, 32'h0000_0000, 0, 4'h0, 5'd0, 0, "R8");
    cap(2'd2, 32'h0000_0004, 0, 4'h4, 5'd0, 0, "R8");
    idle(12);
    cap(2'd0, 32'h0000_00A5, 0, 4'h1, 5'd0, 1, "R8 third");
    idle(8);

    // R6 sizes
    cap(2'd1, 32'h0000_1234, 0, 4'h2, 5'd0, 1, "R6 word");
    idle(8);
    cap(2'd2, 32'hDEAD_BEEF, 0, 4'h4, 5'd0, 1, "R6 long");
    idle(12);
    cap(2'd3, 32'h0BAD_F00D, 0, 4'h4, 5'd0, 1, "R6 size3");
    idle(12);

    // R7 disabled sizes
    cfg_i = 4'b0001;
    cap(2'd0, 32'h0000_0077, 0, 4'h1, 5'd0, 0, "R7");
    cap(2'd2, 32'h1111_2222, 0, 4'h4, 5'd0, 0, "R7");
    idle(12);
    cfg_i = 4'hF;

    // R2 halt wins over instruction start
    halt_i = 1; insn_start_i = 1;
    @(negedge clk);
    chk("R2 halt", pst_o, 4'hF);
    idle(2);

    // R5 instruction start
    insn_start_i = 1;
    @(negedge clk);
    chk("R5 insn", pst_o, 4'h1);
    idle(2);

    // R3 branch with target shown
    branch(0, 3'd5, 32'h89AB_CDEF, 1, "R3");
    @(negedge clk);
    chk("R3 target marker", pst_o, 4'hD);
    idle(12);
    cfg_i = 4'b1110;
    branch(0, 3'd0, 32'h1357_9BDF, 0, "R3 disabled");
    idle(12);
    cfg_i = 4'hF;

    // R4 jump addressing modes
    branch(1, 3'd2, 32'hA000_0010, 1, "R4 indexed");
    idle(12);
    branch(1, 3'd5, 32'hA000_0020, 0, "R4 absolute");
    idle(4);
    branch(1, 3'd6, 32'hA000_0030, 0, "R4 immediate");
    idle(4);
    branch(1, 3'd3, 32'hA000_0040, 1, "R4 pc-indexed");
    idle(12);

    // R9 line-sized move transfers
    cap(2'd2, 32'h5555_0001, 1, 4'h0, 5'd4, 0, "R9");
    cap(2'd2, 32'h5555_0002, 1, 4'h0, 5'd16, 0, "R9");
    idle(4);
    cap(2'd2, 32'h5555_0003, 1, 4'h0, 5'd3, 1, "R9 few regs");
    idle(12);
    cap(2'd2, 32'h5555_0004, 1, 4'h8, 5'd8, 1, "R9 unaligned");
    idle(12);

    // R10 exception status and marker displacement
    exc_i = 1;
    @(negedge clk);
    chk("R10 exc", pst_o, 4'hC);
    cap(2'd2, 32'hC0DE_0008, 0, 4'h8, 5'd0, 1, "R10 frame");
    chk("R10 exc before marker", pst_o, 4'hC);
    @(negedge clk);
    chk("R10 marker wins", pst_o, 4'hB);
    @(negedge clk);
    chk("R10 exc resumes", pst_o, 4'hC);
    idle(10);
    exc_i = 0;
    idle(2);

    // R11 marker held off by instruction starts, then back-to-back words
    insn_start_i = 1;
    cap(2'd0, 32'h0000_003C, 0, 4'h1, 5'd0, 1, "R11 deferred");
    chk("R11 insn 1", pst_o, 4'h1);
    @(negedge clk);
    chk("R11 insn 2", pst_o, 4'h1);
    @(negedge clk);
    chk("R11 insn 3", pst_o, 4'h1);
    insn_start_i = 0;
    @(negedge clk);
    chk("R11 deferred marker", pst_o, 4'h8);
    idle(6);
    cap(2'd1, 32'h0000_ABCD, 0, 4'h2, 5'd0, 1, "R11 pair a");
    cap(2'd1, 32'h0000_4321, 0, 4'h2, 5'd0, 1, "R11 pair b");
    idle(16);

    // R12 fill the queue
    cap(2'd2, 32'h1000_0001, 0, 4'h4, 5'd0, 1, "R12 w1");
    cap(2'd2, 32'h1000_0002, 0, 4'h4, 5'd0, 1, "R12 w2");
    cap(2'd2, 32'h1000_0003, 0, 4'h4, 5'd0, 1, "R12 w3");
    cap(2'd2, 32'h1000_0004, 0, 4'h4, 5'd0, 1, "R12 w4");
    chk("R12 stall low at three", stall_o, 1'b0);
    cap(2'd2, 32'h1000_0005, 0, 4'h4, 5'd0, 1, "R12 w5");
    chk("R12 stall high at four", stall_o, 1'b1);
    cap(2'd2, 32'h1000_0006, 0, 4'h4, 5'd0, 0, "R12 dropped");
    idle(60);
    chk("R12 stall released", stall_o, 1'b0);

    chk("R11 all expected words seen", exp_mark_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule